// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address for an instruction fetch, a data load or a data store. It reads up to two levels of page table from memory over a simple request/response port and checks the leaf entry against the access type and the effective privilege. When a leaf is accepted but its accessed or dirty flag has to change, the walker writes the entry back before it reports. It returns a physical address and a read/write/execute permission set for a TLB, or a page-fault cause.

A request is taken when `req_valid` and `req_ready` are both high at a clock edge. The configuration inputs are sampled in that same cycle. Exactly one completion pulse on `done_valid` answers each request. Machine privilege and disabled paging skip the walk altogether.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is high and `done_valid` and `mem_req_valid` are low.
- R2: When paging is off, or when the effective privilege is machine (code 2'b11), the result is the virtual address zero-extended to 34 bits with permission 3'b111 and no fault. No memory transaction takes place.
- R3: With privilege machine and `cfg_mprv` set, loads and stores use `cfg_mpp` as their effective privilege. Fetches always keep machine privilege. Privilege codes are user 2'b00 and supervisor 2'b01.
- R4: The first read goes to `cfg_root_ppn`*4096 + vaddr[31:22]*4. After a pointer entry, the second read goes to that entry's PPN*4096 + vaddr[21:12]*4. The entry bits are V=0, R=1, W=2, X=3, U=4, A=6 and D=7, and the PPN sits in bits [31:10].
- R5: An entry with V clear faults. So does a pointer entry (R, W and X all clear) found at the second level.
- R6: A leaf with W set and R clear is reserved and faults.
- R7: A page with U set faults for a non-user privilege if `cfg_sum` is clear or the access is a fetch. A page with U clear faults unless the privilege is supervisor.
- R8: A first-level leaf whose PPN bits [9:0] are not zero faults.
- R9: A load needs R, or X with `cfg_mxr` set. A store needs W. A fetch needs X. Access codes are fetch 2'b00, load 2'b01 and store 2'b10.
- R10: An accepted leaf gains A, and gains D as well on a store. If the entry changes, it is written back to the address it was read from before completion. If it does not change, no write happens.
- R11: A first-level leaf yields the physical address {PPN[21:10], vaddr[21:0]}. A second-level leaf yields {PPN, vaddr[11:0]}.
- R12: `done_perm` is {R, W, X}. Read permission is R or (X and `cfg_mxr`). Write permission is W and (store or D already set). Execute permission is X.
- R13: A fault reports cause 12 for a fetch, 13 for a load and 15 for a store, with physical address and permission zero.
- R14: The memory port has at most one transaction in flight. A stalled request holds its address and kind. `done_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: fetch, load or store |
| req_priv | input | 2 | Current privilege |
| cfg_paging_en | input | 1 | Two-level translation enabled |
| cfg_root_ppn | input | 22 | Page number of the root table |
| cfg_sum | input | 1 | Supervisor may touch user pages |
| cfg_mxr | input | 1 | Executable pages count as readable |
| cfg_mprv | input | 1 | Machine data accesses use `cfg_mpp` |
| cfg_mpp | input | 2 | Privilege substituted under `cfg_mprv` |
| mem_req_valid | output | 1 | Memory transaction request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 34 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_rdata | input | 32 | Entry read from memory |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Translation failed |
| done_cause | output | 4 | Fault cause code |
| done_paddr | output | 34 | Physical address |
| done_perm | output | 3 | Permission {R, W, X} |

## Verification
The bench uses the package defaults: 32-bit addresses, 10-bit indices, 4 KiB pages and a 34-bit physical space. With these, a table of a dozen entries placed in a sparse bench memory covers every leaf check, a superpage and both write-back cases. Alternating `mem_req_ready` stalls are mixed in with ready-always runs, so the hold-while-stalled and single-outstanding rules are exercised on reads and on write-backs.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W   = 32;
    localparam int PG_OFF = 12;
    localparam int IDX_W  = 10;
    localparam int PTE_W  = 32;
    localparam int PPN_W  = 22;
    localparam int PA_W   = PPN_W + PG_OFF;
    localparam int PPN_LO = PTE_W - PPN_W;

    localparam int PTE_V = 0;
    localparam int PTE_R = 1;
    localparam int PTE_WB = 2;
    localparam int PTE_X = 3;
    localparam int PTE_U = 4;
    localparam int PTE_A = 6;
    localparam int PTE_D = 7;

    localparam logic [1:0] ACC_FETCH = 2'b00;
    localparam logic [1:0] ACC_LOAD  = 2'b01;
    localparam logic [1:0] ACC_STORE = 2'b10;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef struct packed {
        logic            fault;
        logic [3:0]      cause;
        logic [PA_W-1:0] paddr;
        perm_t           perm;
    } result_t;

    function automatic logic [3:0] page_fault_cause(input logic [1:0] acc);
        case (acc)
            ACC_FETCH: page_fault_cause = 4'd12;
            ACC_LOAD:  page_fault_cause = 4'd13;
            default:   page_fault_cause = 4'd15;
        endcase
    endfunction

    function automatic logic [PPN_W-1:0] pte_ppn(input logic [PTE_W-1:0] pte);
        pte_ppn = pte[PTE_W-1:PPN_LO];
    endfunction
endpackage

// File: rtl/ptw_priv_sel.sv
module ptw_priv_sel
    import ptw_pkg::*;
(
    input  logic [1:0] acc,
    input  logic [1:0] priv,
    input  logic       mprv,
    input  logic [1:0] mpp,
    input  logic       paging_en,
    output logic [1:0] eff_priv,
    output logic       bypass
);
    always_comb begin
        if (priv == PRIV_M && mprv && acc != ACC_FETCH)
            eff_priv = mpp;
        else
            eff_priv = priv;
        bypass = !paging_en || (eff_priv == PRIV_M);
    end
endmodule

// File: rtl/ptw_leaf_chk.sv
module ptw_leaf_chk
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic             super_lvl,
    input  logic [1:0]       acc,
    input  logic [1:0]       priv,
    input  logic             sum,
    input  logic             mxr,
    output logic             is_ptr,
    output logic             leaf_ok,
    output perm_t            perm,
    output logic [PTE_W-1:0] pte_upd,
    output logic             upd_needed
);
    logic v, r, w, x, u, d;
    logic rsvd, u_bad, mis, acc_bad;
    logic [PPN_W-1:0] ppn;

    always_comb begin
        v   = pte[PTE_V];
        r   = pte[PTE_R];
        w   = pte[PTE_WB];
        x   = pte[PTE_X];
        u   = pte[PTE_U];
        d   = pte[PTE_D];
        ppn = pte_ppn(pte);

        rsvd = w && !r;
        if (u)
            u_bad = (priv != PRIV_U) && (!sum || acc == ACC_FETCH);
        else
            u_bad = (priv != PRIV_S);
        mis = super_lvl && (ppn[IDX_W-1:0] != '0);
        case (acc)
            ACC_LOAD:  acc_bad = !(r || (x && mxr));
            ACC_STORE: acc_bad = !w;
            ACC_FETCH: acc_bad = !x;
            default:   acc_bad = 1'b1;
        endcase

        is_ptr  = v && !(r || w || x);
        leaf_ok = v && (r || w || x) && !rsvd && !u_bad && !mis && !acc_bad;

        perm.r = r || (x && mxr);
        perm.w = w && ((acc == ACC_STORE) || d);
        perm.x = x;

        pte_upd = pte;
        pte_upd[PTE_A] = 1'b1;
        if (acc == ACC_STORE)
            pte_upd[PTE_D] = 1'b1;
        upd_needed = (pte_upd != pte);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [1:0]        req_priv,
    input  logic              cfg_paging_en,
    input  logic [PPN_W-1:0]  cfg_root_ppn,
    input  logic              cfg_sum,
    input  logic              cfg_mxr,
    input  logic              cfg_mprv,
    input  logic [1:0]        cfg_mpp,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_rdata,
    output logic              done_valid,
    output logic              done_fault,
    output logic [3:0]        done_cause,
    output logic [PA_W-1:0]   done_paddr,
    output logic [2:0]        done_perm
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WB_REQ, ST_WB_WAIT, ST_DONE
    } st_e;

    localparam int ENT_SH = 2;

    st_e              st;
    logic             lvl_hi;
    logic [VA_W-1:0]  va_q;
    logic [1:0]       acc_q;
    logic [1:0]       priv_q;
    logic             sum_q;
    logic             mxr_q;
    logic [PPN_W-1:0] base_q;
    logic [PTE_W-1:0] wdata_q;
    result_t          res_q;

    logic [1:0]       eff_priv;
    logic             bypass;
    logic             chk_ptr, chk_ok, chk_upd;
    perm_t            chk_perm;
    logic [PTE_W-1:0] chk_pte_upd;
    logic [IDX_W-1:0] cur_idx;
    logic [PPN_W-1:0] rsp_ppn;
    logic [PA_W-1:0]  leaf_pa;

    ptw_priv_sel u_priv (
        .acc       (req_acc),
        .priv      (req_priv),
        .mprv      (cfg_mprv),
        .mpp       (cfg_mpp),
        .paging_en (cfg_paging_en),
        .eff_priv  (eff_priv),
        .bypass    (bypass)
    );

    ptw_leaf_chk u_chk (
        .pte        (mem_rsp_rdata),
        .super_lvl  (lvl_hi),
        .acc        (acc_q),
        .priv       (priv_q),
        .sum        (sum_q),
        .mxr        (mxr_q),
        .is_ptr     (chk_ptr),
        .leaf_ok    (chk_ok),
        .perm       (chk_perm),
        .pte_upd    (chk_pte_upd),
        .upd_needed (chk_upd)
    );

    always_comb begin
        cur_idx = lvl_hi ? va_q[VA_W-1:PG_OFF+IDX_W] : va_q[PG_OFF+IDX_W-1:PG_OFF];
        rsp_ppn = pte_ppn(mem_rsp_rdata);
        if (lvl_hi)
            leaf_pa = {rsp_ppn[PPN_W-1:IDX_W], va_q[PG_OFF+IDX_W-1:0]};
        else
            leaf_pa = {rsp_ppn, va_q[PG_OFF-1:0]};
    end

    assign req_ready     = (st == ST_IDLE);
    assign mem_req_valid = (st == ST_RD_REQ) || (st == ST_WB_REQ);
    assign mem_req_write = (st == ST_WB_REQ);
    assign mem_req_addr  = {base_q, {PG_OFF{1'b0}}} + PA_W'({cur_idx, {ENT_SH{1'b0}}});
    assign mem_req_wdata = wdata_q;
    assign done_valid    = (st == ST_DONE);
    assign done_fault    = res_q.fault;
    assign done_cause    = res_q.cause;
    assign done_paddr    = res_q.paddr;
    assign done_perm     = res_q.perm;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            lvl_hi  <= 1'b1;
            va_q    <= '0;
            acc_q   <= ACC_FETCH;
            priv_q  <= PRIV_U;
            sum_q   <= 1'b0;
            mxr_q   <= 1'b0;
            base_q  <= '0;
            wdata_q <= '0;
            res_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    acc_q  <= req_acc;
                    priv_q <= eff_priv;
                    sum_q  <= cfg_sum;
                    mxr_q  <= cfg_mxr;
                    base_q <= cfg_root_ppn;
                    lvl_hi <= 1'b1;
                    if (bypass) begin
                        res_q.fault <= 1'b0;
                        res_q.cause <= '0;
                        res_q.paddr <= PA_W'(req_vaddr);
                        res_q.perm  <= 3'b111;
                        st          <= ST_DONE;
                    end else begin
                        st <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ: if (mem_req_ready) st <= ST_RD_WAIT;
                ST_RD_WAIT: if (mem_rsp_valid) begin
                    if (chk_ptr && lvl_hi) begin
                        base_q <= rsp_ppn;
                        lvl_hi <= 1'b0;
                        st     <= ST_RD_REQ;
                    end else if (chk_ok) begin
                        res_q.fault <= 1'b0;
                        res_q.cause <= '0;
                        res_q.paddr <= leaf_pa;
                        res_q.perm  <= chk_perm;
                        wdata_q     <= chk_pte_upd;
                        st          <= chk_upd ? ST_WB_REQ : ST_DONE;
                    end else begin
                        res_q.fault <= 1'b1;
                        res_q.cause <= page_fault_cause(acc_q);
                        res_q.paddr <= '0;
                        res_q.perm  <= '0;
                        st          <= ST_DONE;
                    end
                end
                ST_WB_REQ:  if (mem_req_ready) st <= ST_WB_WAIT;
                ST_WB_WAIT: if (mem_rsp_valid) st <= ST_DONE;
                default:    st <= ST_IDLE;
            endcase
        end
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R14
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R14
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid); // R14
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault) |-> (done_perm == 3'b000 && done_paddr == '0)); // R13
    AST_WB_MARKS_ACCESSED: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[PTE_A] && mem_req_wdata[PTE_V])); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R14
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [1:0]  req_priv = '0;
    logic        cfg_paging_en = 1'b0;
    logic [21:0] cfg_root_ppn = 22'h100;
    logic        cfg_sum = 1'b0;
    logic        cfg_mxr = 1'b0;
    logic        cfg_mprv = 1'b0;
    logic [1:0]  cfg_mpp = 2'b00;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [33:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        done_valid;
    logic        done_fault;
    logic [3:0]  done_cause;
    logic [33:0] done_paddr;
    logic [2:0]  done_perm;

    always #2.5 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .req_priv(req_priv),
        .cfg_paging_en(cfg_paging_en), .cfg_root_ppn(cfg_root_ppn),
        .cfg_sum(cfg_sum), .cfg_mxr(cfg_mxr), .cfg_mprv(cfg_mprv), .cfg_mpp(cfg_mpp),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done_valid(done_valid),
        .done_fault(done_fault), .done_cause(done_cause),
        .done_paddr(done_paddr), .done_perm(done_perm)
    );

    localparam logic [1:0] F = 2'b00, L = 2'b01, S = 2'b10;
    localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;

    int total = 0;
    int bad = 0;
    bit stall = 1'b0;

    logic [31:0] mem [logic [33:0]];
    logic [33:0] rd_log [$];
    int          wr_total = 0;
    logic [33:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;

    typedef struct {
        string       tag;
        logic        fault;
        logic [3:0]  cause;
        logic [33:0] pa;
        logic [2:0]  perm;
        int          nrd;
        int          nwr;
        logic [31:0] wd;
        int          rd_base;
        int          wr_base;
        logic [33:0] a0;
        logic [33:0] a1;
    } exp_t;
    exp_t exp_q [$];

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: ready decided first, then handshake sampled, response one cycle later
    initial begin
        logic        pend = 1'b0;
        logic [31:0] pdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = pdata;
                pend = 1'b0;
            end
            mem_req_ready = stall ? ~mem_req_ready : 1'b1;
            if (!rst && mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem[mem_req_addr] = mem_req_wdata;
                    wr_total++;
                    last_wr_addr = mem_req_addr;
                    last_wr_data = mem_req_wdata;
                    pdata = '0;
                end else begin
                    rd_log.push_back(mem_req_addr);
                    pdata = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
                end
                pend = 1'b1;
            end
        end
    end

    // monitor: pops the expected item on each completion pulse
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R14", "unexpected completion", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    int nr, nw;
                    e = exp_q.pop_front();
                    nr = rd_log.size() - e.rd_base;
                    nw = wr_total - e.wr_base;
                    chk(e.tag, "fault", 64'(done_fault), 64'(e.fault));
                    chk(e.tag, "paddr", 64'(done_paddr), 64'(e.pa));
                    chk(e.tag, "perm", 64'(done_perm), 64'(e.perm));
                    if (e.fault) chk("R13", {e.tag, " cause"}, 64'(done_cause), 64'(e.cause));
                    chk(e.tag, "reads", 64'(nr), 64'(e.nrd));
                    chk("R10", {e.tag, " writes"}, 64'(nw), 64'(e.nwr));
                    if (nr >= 1 && e.nrd >= 1)
                        chk("R4", {e.tag, " first read addr"}, 64'(rd_log[e.rd_base]), 64'(e.a0));
                    if (nr >= 2 && e.nrd >= 2)
                        chk("R4", {e.tag, " second read addr"}, 64'(rd_log[e.rd_base+1]), 64'(e.a1));
                    if (nw >= 1 && e.nwr >= 1) begin
                        chk("R10", {e.tag, " wb addr"}, 64'(last_wr_addr), 64'(e.a1));
                        chk("R10", {e.tag, " wb data"}, 64'(last_wr_data), 64'(e.wd));
                    end
                end
            end
        end
    end

    // driver: pushes the expectation, issues the request, waits for the monitor
    task automatic run(input string tag, input logic [31:0] va, input logic [1:0] acc,
                       input logic [1:0] priv, input logic fault, input logic [3:0] cause,
                       input logic [33:0] pa, input logic [2:0] perm,
                       input int nrd, input int nwr, input logic [31:0] wd);
        exp_t e;
        e.tag = tag; e.fault = fault; e.cause = cause; e.pa = pa; e.perm = perm;
        e.nrd = nrd; e.nwr = nwr; e.wd = wd;
        e.rd_base = rd_log.size(); e.wr_base = wr_total;
        e.a0 = 34'({cfg_root_ppn, 12'h000}) + 34'({va[31:22], 2'b00});
        e.a1 = 34'h0020_0000 + 34'({va[21:12], 2'b00});
        exp_q.push_back(e);
        @(negedge clk);
        req_vaddr = va; req_acc = acc; req_priv = priv; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mem[34'h100004] = 32'h0008_0001;
        mem[34'h100008] = 32'h0010_00CF;
        mem[34'h10000C] = 32'h0010_04CF;
        mem[34'h200000] = 32'h048D_14C7;
        mem[34'h200004] = 32'h002A_F01F;
        mem[34'h200008] = 32'h001D_DC07;
        mem[34'h20000C] = 32'h0000_0005;
        mem[34'h200010] = 32'h0000_000D;
        mem[34'h200014] = 32'h0000_0000;
        mem[34'h200018] = 32'h0000_0001;
        mem[34'h20001C] = 32'h000C_CC49;
        mem[34'h200020] = 32'h0015_5453;
        mem[34'h200024] = 32'h0015_5859;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "done_valid", 64'(done_valid), 64'd0);
        chk("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);

        cfg_paging_en = 1'b0;
        run("R2 bare", 32'hDEAD_BEEF, L, PS, 0, 0, 34'h0_DEAD_BEEF, 3'b111, 0, 0, 0);
        cfg_paging_en = 1'b1;
        run("R4 R12 level0 load", 32'h0040_0123, L, PS, 0, 0, 34'h1234_5123, 3'b110, 2, 0, 0);
        stall = 1'b1;
        run("R10 store wb", 32'h0040_1ABC, S, PU, 0, 0, 34'h00AB_CABC, 3'b111, 2, 1, 32'h002A_F0DF);
        run("R10 store no wb", 32'h0040_1ABC, S, PU, 0, 0, 34'h00AB_CABC, 3'b111, 2, 0, 0);
        run("R12 load clean wb", 32'h0040_2010, L, PS, 0, 0, 34'h0077_7010, 3'b100, 2, 1, 32'h001D_DC47);
        run("R6 w only", 32'h0040_3000, L, PS, 1, 13, 0, 0, 2, 0, 0);
        run("R6 wx", 32'h0040_4000, F, PS, 1, 12, 0, 0, 2, 0, 0);
        run("R5 invalid", 32'h0040_5000, S, PS, 1, 15, 0, 0, 2, 0, 0);
        stall = 1'b0;
        run("R5 ptr at leaf level", 32'h0040_6000, L, PS, 1, 13, 0, 0, 2, 0, 0);
        run("R9 xonly load", 32'h0040_7004, L, PS, 1, 13, 0, 0, 2, 0, 0);
        cfg_mxr = 1'b1;
        run("R9 R12 xonly load mxr", 32'h0040_7004, L, PS, 0, 0, 34'h0033_3004, 3'b101, 2, 0, 0);
        cfg_mxr = 1'b0;
        run("R9 xonly fetch", 32'h0040_7004, F, PS, 0, 0, 34'h0033_3004, 3'b001, 2, 0, 0);
        run("R9 xonly store", 32'h0040_7004, S, PS, 1, 15, 0, 0, 2, 0, 0);
        run("R7 user page sum0", 32'h0040_8000, L, PS, 1, 13, 0, 0, 2, 0, 0);
        cfg_sum = 1'b1;
        run("R7 user page sum1", 32'h0040_8000, L, PS, 0, 0, 34'h0055_5000, 3'b100, 2, 0, 0);
        run("R7 user page fetch", 32'h0040_9000, F, PS, 1, 12, 0, 0, 2, 0, 0);
        cfg_sum = 1'b0;
        run("R7 sup page from user", 32'h0040_0123, L, PU, 1, 13, 0, 0, 2, 0, 0);
        run("R11 superpage", 32'h0080_5678, L, PS, 0, 0, 34'h0040_5678, 3'b111, 1, 0, 0);
        run("R8 misaligned superpage", 32'h00C0_0000, L, PS, 1, 13, 0, 0, 1, 0, 0);
        run("R2 machine", 32'h0040_0010, F, PM, 0, 0, 34'h0_0040_0010, 3'b111, 0, 0, 0);
        cfg_mprv = 1'b1; cfg_mpp = PS;
        run("R3 mprv load as S", 32'h0040_0123, L, PM, 0, 0, 34'h1234_5123, 3'b110, 2, 0, 0);
        cfg_mpp = PU;
        run("R3 mprv fetch stays M", 32'h0040_0123, F, PM, 0, 0, 34'h0_0040_0123, 3'b111, 0, 0, 0);
        run("R3 mprv load as U", 32'h0040_0123, L, PM, 1, 13, 0, 0, 2, 0, 0);
        cfg_mprv = 1'b0;

        repeat (4) @(negedge clk);
        chk("R14", "idle after run", 64'(req_ready), 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule